// File: doc/BRIEF.md
# Repeating Block Copy and Byte Scan Engine

This block carries out one repeated byte-block instruction on behalf of a processor core. It is handed a two-byte opcode together with a source pointer (HL), a destination pointer (DE), a 16-bit byte count (BC), an accumulator value (A) and the current flag byte. It then walks memory one byte per iteration until the work is finished. The two copy modes move bytes from HL to DE with both pointers stepping up or both stepping down. The two scan modes compare each byte at HL against A. They step HL up or down and stop early when a byte equals A.

Each iteration is a fixed run of clock states. An iteration that will be followed by another one takes 21 clocks. The last iteration takes 16 clocks. Memory is reached through a synchronous port whose read data arrives one clock after the read strobe. The updated pointers, count and flags are shown on dedicated outputs, and a one-clock done pulse marks the end.

Commands use a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A command offered while it is low is not taken, and the caller must hold `cmd_valid` until it sees ready. The memory port, done and busy are plain pins with no back-pressure.

Top module: `blk_engine`

## Requirements
- R1: A command is accepted only when the prefix byte is 0xED and the second byte is 0xB0 (copy, pointers up), 0xB8 (copy, pointers down), 0xB1 (scan, HL up) or 0xB9 (scan, HL down). Any other byte pair is dropped without starting: busy stays low, no memory strobe is raised, and the register outputs keep their values.
- R2: In the copy modes, each iteration writes the byte read at address HL to address DE. HL and DE each move by +1 (0xB0) or -1 (0xB8) and BC drops by one. The run ends when BC reaches zero. Overlapping source and destination ranges behave as strictly sequential byte moves.
- R3: In the scan modes, each iteration reads the byte at HL, moves HL by +1 (0xB1) or -1 (0xB9) and drops BC by one. DE and memory are left untouched. The run ends when the decremented BC is zero or when the byte equals A.
- R4: An iteration followed by another one lasts 21 clocks and the final iteration lasts 16 clocks. For N iterations, done rises exactly 21*(N-1)+16 clocks after the accepting clock edge.
- R5: In each iteration, exactly one read strobe is raised, at clock offset 4 from the start of the iteration, addressed by HL. In copy modes, exactly one write strobe is raised, at offset 8, addressed by DE. No strobe is raised at any other time, and read and write are never raised together.
- R6: In the copy modes, flag bits 4 (half-borrow), 2 (parity/overflow) and 1 (subtract) are cleared after every iteration, and bits 7, 6, 5, 3 and 0 keep their incoming values.
- R7: In the scan modes, the flags reflect the last byte compared. Bit 7 is bit 7 of A minus the byte, bit 6 is set when A equals the byte, bit 4 is set when the low nibble of A is below the low nibble of the byte, and bit 1 is set. Bits 5, 3 and 0 keep their incoming values.
- R8: In the scan modes, flag bit 2 is set when BC after the decrement is nonzero and cleared when it is zero.
- R9: A starting BC of zero counts as 65536 bytes: the first iteration leaves BC at 0xFFFF and does not end the run on count.
- R10: done is a single-clock pulse. busy falls on the same clock, and the final HL, DE, BC and flags are already valid in that clock.
- R11: cmd_ready is low whenever busy is high, and a command offered during a run changes neither the run nor its results.
- R12: An active-high synchronous reset returns the engine to idle at once, from any point in a run: busy, done and both strobes go low and cmd_ready goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_pfx | input | 8 | First opcode byte |
| cmd_op | input | 8 | Second opcode byte |
| hl_in | input | AW | Initial source pointer |
| de_in | input | AW | Initial destination pointer |
| bc_in | input | AW | Initial byte count (zero means 65536) |
| acc_in | input | DW | Accumulator value for scans |
| flags_in | input | 8 | Incoming flag byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the clock after mem_rd |
| hl_out | output | AW | Current source pointer |
| de_out | output | AW | Current destination pointer |
| bc_out | output | AW | Current byte count |
| flags_out | output | 8 | Current flag byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |

## Verification
Copies are swept over counts 1 to 8 in both directions. They alternate all-ones and all-zeros incoming flags, so a kept bit can be told apart from a cleared one. An overlapping forward copy separates sequential byte moves from a buffered block move. Scans place the matching byte at every position from the first byte to past the count, with several accumulator values. This separates termination on a match from termination on count, exercises both values of the sign, half-borrow and count flags, and gives timings for every iteration count. A zero start count with a second-byte match, a pointer wrap through address zero, a command offered mid-run, illegal opcodes and a reset mid-run each test one edge rule.

// File: rtl/blk_pkg.sv
package blk_pkg;

  typedef enum logic [1:0] {
    MODE_COPY_UP = 2'd0,
    MODE_COPY_DN = 2'd1,
    MODE_SCAN_UP = 2'd2,
    MODE_SCAN_DN = 2'd3
  } blk_mode_e;

  localparam logic [7:0] OPC_PREFIX  = 8'hED;
  localparam logic [7:0] OPC_COPY_UP = 8'hB0;
  localparam logic [7:0] OPC_COPY_DN = 8'hB8;
  localparam logic [7:0] OPC_SCAN_UP = 8'hB1;
  localparam logic [7:0] OPC_SCAN_DN = 8'hB9;

  // flag byte bit positions (decoded by the surrounding core)
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_H  = 4;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  // clock states of each phase of one iteration
  localparam int PH_OPC  = 4;
  localparam int PH_OPC2 = 4;
  localparam int PH_RD   = 3;
  localparam int PH_WR   = 5;
  localparam int PH_RPT  = 5;

  localparam int T_READ   = PH_OPC;
  localparam int T_WRITE  = PH_OPC + PH_OPC2;
  localparam int T_UPDATE = PH_OPC + PH_OPC2 + PH_RD + PH_WR - 1;
  localparam int T_LAST   = PH_OPC + PH_OPC2 + PH_RD + PH_WR + PH_RPT - 1;

endpackage

// File: rtl/blk_decode.sv
module blk_decode
  import blk_pkg::*;
(
  input  logic [7:0] pfx,
  input  logic [7:0] op,
  output logic       ok,
  output blk_mode_e  mode
);
  always_comb begin
    ok   = (pfx == OPC_PREFIX);
    mode = MODE_COPY_UP;
    unique case (op)
      OPC_COPY_UP: mode = MODE_COPY_UP;
      OPC_COPY_DN: mode = MODE_COPY_DN;
      OPC_SCAN_UP: mode = MODE_SCAN_UP;
      OPC_SCAN_DN: mode = MODE_SCAN_DN;
      default:     ok   = 1'b0;
    endcase
  end
endmodule

// File: rtl/blk_step.sv
module blk_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         down,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  assign nxt = down ? (cur - ONE) : (cur + ONE);
endmodule

// File: rtl/blk_tcount.sv
module blk_tcount #(
  parameter int LAST = 20,
  localparam int CW  = $clog2(LAST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] C_LAST = CW'(LAST);
  always_ff @(posedge clk) begin
    if (rst || !adv)        cnt <= '0;
    else if (cnt == C_LAST) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/blk_flags.sv
module blk_flags
  import blk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [7:0]    f_old,
  input  logic          scan,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mbyte,
  input  logic          cnt_nz,
  output logic [7:0]    f_new
);
  logic [DW-1:0] diff;
  always_comb begin
    diff  = acc - mbyte;
    f_new = f_old;
    if (scan) begin
      f_new[FB_S]  = diff[DW-1];
      f_new[FB_Z]  = (acc == mbyte);
      f_new[FB_H]  = (acc[3:0] < mbyte[3:0]);
      f_new[FB_PV] = cnt_nz;
      f_new[FB_N]  = 1'b1;
    end else begin
      f_new[FB_H]  = 1'b0;
      f_new[FB_PV] = 1'b0;
      f_new[FB_N]  = 1'b0;
    end
  end
endmodule

// File: rtl/blk_engine.sv
module blk_engine
  import blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_pfx,
  input  logic [7:0]    cmd_op,
  input  logic [AW-1:0] hl_in,
  input  logic [AW-1:0] de_in,
  input  logic [AW-1:0] bc_in,
  input  logic [DW-1:0] acc_in,
  input  logic [7:0]    flags_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] de_out,
  output logic [AW-1:0] bc_out,
  output logic [7:0]    flags_out,
  output logic          busy,
  output logic          done
);
  localparam int CW = $clog2(T_LAST + 1);
  localparam logic [CW-1:0] C_RD  = CW'(T_READ);
  localparam logic [CW-1:0] C_CAP = CW'(T_READ + 1);
  localparam logic [CW-1:0] C_WR  = CW'(T_WRITE);
  localparam logic [CW-1:0] C_UPD = CW'(T_UPDATE);
  localparam logic [AW-1:0] ONE   = {{(AW-1){1'b0}}, 1'b1};

  logic          busy_q, done_q;
  blk_mode_e     mode_q;
  logic [AW-1:0] hl_q, de_q, bc_q;
  logic [DW-1:0] acc_q, rbuf_q;
  logic [7:0]    f_q;
  logic [CW-1:0] tcnt;

  logic          dec_ok;
  blk_mode_e     dec_mode;
  logic          accept, scan, down;
  logic          rd_ph, cap_ph, wr_ph, upd_ph, finish;
  logic [AW-1:0] hl_nx, de_nx, bc_nx;
  logic [7:0]    f_nx;

  blk_decode u_dec (
    .pfx  (cmd_pfx),
    .op   (cmd_op),
    .ok   (dec_ok),
    .mode (dec_mode)
  );

  assign scan = mode_q[1];
  assign down = mode_q[0];

  blk_tcount #(.LAST(T_LAST)) u_tc (
    .clk (clk),
    .rst (rst),
    .adv (busy_q && !finish),
    .cnt (tcnt)
  );

  blk_step #(.W(AW)) u_hl_step (.cur(hl_q), .down(down), .nxt(hl_nx));
  blk_step #(.W(AW)) u_de_step (.cur(de_q), .down(down), .nxt(de_nx));

  assign bc_nx = bc_q - ONE;

  blk_flags #(.DW(DW)) u_flags (
    .f_old  (f_q),
    .scan   (scan),
    .acc    (acc_q),
    .mbyte  (rbuf_q),
    .cnt_nz (bc_nx != '0),
    .f_new  (f_nx)
  );

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready && dec_ok;

  assign rd_ph  = busy_q && (tcnt == C_RD);
  assign cap_ph = busy_q && (tcnt == C_CAP);
  assign wr_ph  = busy_q && !scan && (tcnt == C_WR);
  assign upd_ph = busy_q && (tcnt == C_UPD);
  assign finish = upd_ph && ((bc_nx == '0) || (scan && (acc_q == rbuf_q)));

  assign mem_rd    = rd_ph;
  assign mem_wr    = wr_ph;
  assign mem_addr  = wr_ph ? de_q : hl_q;
  assign mem_wdata = rbuf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= MODE_COPY_UP;
      hl_q   <= '0;
      de_q   <= '0;
      bc_q   <= '0;
      acc_q  <= '0;
      rbuf_q <= '0;
      f_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= dec_mode;
        hl_q   <= hl_in;
        de_q   <= de_in;
        bc_q   <= bc_in;
        acc_q  <= acc_in;
        f_q    <= flags_in;
      end
      if (cap_ph) rbuf_q <= mem_rdata;
      if (upd_ph) begin
        hl_q <= hl_nx;
        if (!scan) de_q <= de_nx;
        bc_q <= bc_nx;
        f_q  <= f_nx;
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign hl_out    = hl_q;
  assign de_out    = de_q;
  assign bc_out    = bc_q;
  assign flags_out = f_q;
  assign busy      = busy_q;
  assign done      = done_q;

endmodule

// File: rtl/blk_engine_chk.sv
module blk_engine_chk
  import blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          cmd_ready,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] bc_out,
  input logic [7:0]    flags_out,
  input logic [1:0]    mode,
  input logic [CW-1:0] tcnt
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);                                              // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));                                              // R5
  AST_RD_PHASE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (busy && tcnt == CW'(T_READ)));                         // R5
  AST_WR_PHASE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (busy && tcnt == CW'(T_WRITE)));                        // R5
  AST_SCAN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy && mode[1]) |-> !mem_wr);                                    // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                   // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                                   // R10
  AST_COPY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (done && !mode[1]) |-> (flags_out[FB_H] == 1'b0 && flags_out[FB_PV] == 1'b0
                            && flags_out[FB_N] == 1'b0));              // R6
  AST_SCAN_NSET: assert property (@(posedge clk) disable iff (rst)
    (done && mode[1]) |-> flags_out[FB_N]);                            // R7
  AST_BC_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && bc_out != $past(bc_out))
      |-> (bc_out == $past(bc_out) - 1'b1));                           // R2
endmodule

bind blk_engine blk_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .cmd_ready (cmd_ready),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .bc_out    (bc_out),
  .flags_out (flags_out),
  .mode      (mode_q),
  .tcnt      (tcnt)
);

// File: tb/tb_blk_engine.sv
module tb_blk_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_pfx = 8'h00, cmd_op = 8'h00;
  logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
  logic [7:0]  acc_in = '0, flags_in = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] hl_out, de_out, bc_out;
  logic [7:0]  flags_out;
  logic        busy, done;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] mem [4096];
  logic [7:0] rm  [4096];

  always #5 clk = ~clk;

  blk_engine dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pfx(cmd_pfx), .cmd_op(cmd_op), .hl_in(hl_in), .de_in(de_in),
    .bc_in(bc_in), .acc_in(acc_in), .flags_in(flags_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
    .flags_out(flags_out), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'((i * 37 + seed * 11 + 5) & 255);
      rm[i]  = mem[i];
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] v);
    mem[a[11:0]] = v;
    rm[a[11:0]]  = v;
  endtask

  // reference run: model, drive, compare
  task automatic run_case(input logic [7:0] op, input logic [15:0] hl, de, bc,
                          input logic [7:0] a, f, input bit intrude);
    logic [15:0] h, d, b;
    logic [7:0]  ff, m, df;
    bit scan, dn, stop;
    int n, cyc, nrd, nwr, bad;
    scan = op[0]; dn = op[3];
    h = hl; d = de; b = bc; ff = f; n = 0; stop = 0;
    while (!stop) begin
      n++;
      m = rm[h[11:0]];
      if (!scan) begin
        rm[d[11:0]] = m;
        d = dn ? d - 16'd1 : d + 16'd1;
      end
      h = dn ? h - 16'd1 : h + 16'd1;
      b = b - 16'd1;
      if (scan) begin
        df = a - m;
        ff[7] = df[7];
        ff[6] = (a == m);
        ff[4] = (a[3:0] < m[3:0]);
        ff[2] = (b != 0);
        ff[1] = 1'b1;
      end else begin
        ff[4] = 1'b0; ff[2] = 1'b0; ff[1] = 1'b0;
      end
      stop = (b == 0) || (scan && a == m);
    end

    @(negedge clk);
    cmd_pfx = 8'hED; cmd_op = op; hl_in = hl; de_in = de; bc_in = bc;
    acc_in = a; flags_in = f; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0; nrd = 0; nwr = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (mem_rd) nrd++;
      if (mem_wr) nwr++;
      if (intrude && cyc == 3) begin
        cmd_valid = 1'b1; cmd_op = 8'hB1; hl_in = 16'h0AAA; bc_in = 16'd1;
        chk(cmd_ready == 1'b0, "R11 ready low while busy", cmd_ready, 0);
      end
      if (intrude && cyc == 4) cmd_valid = 1'b0;
    end
    chk(done == 1'b1, "R10 done pulse seen", done, 1);
    chk(busy == 1'b0, "R10 busy low with done", busy, 0);
    chk(cyc == 21 * (n - 1) + 16, "R4 cycles to done", cyc, 21 * (n - 1) + 16);
    chk(hl_out == h, scan ? "R3 HL final" : "R2 HL final", hl_out, h);
    chk(de_out == d, scan ? "R3 DE untouched" : "R2 DE final", de_out, d);
    chk(bc_out == b, scan ? "R3 BC final" : "R2 BC final", bc_out, b);
    chk(flags_out == ff, scan ? "R7 R8 scan flags" : "R6 copy flags", flags_out, ff);
    chk(nrd == n, "R5 read strobes", nrd, n);
    chk(nwr == (scan ? 0 : n), "R5 write strobes", nwr, scan ? 0 : n);
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] != rm[i]) bad++;
    chk(bad == 0, scan ? "R3 memory unchanged" : "R2 memory contents", bad, 0);
    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] hold_hl;
    int bad;
    logic [7:0] avals [4];
    avals[0] = 8'h5A; avals[1] = 8'h00; avals[2] = 8'h80; avals[3] = 8'h17;
    fill(0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && cmd_ready == 1, "R12 reset state busy/done/ready", busy, 0);
    chk(mem_rd == 0 && mem_wr == 0, "R12 reset state strobes", mem_rd, 0);
    rst = 1'b0;

    // R2 R6 copy sweeps both directions
    for (int k = 1; k <= 8; k++) begin
      run_case(8'hB0, 16'h0100 + 16'(k), 16'h0400 + 16'(k * 3), 16'(k), 8'h33,
               (k % 2) ? 8'hFF : 8'h00, 1'b0);
      run_case(8'hB8, 16'h0700 + 16'(k), 16'h0900 - 16'(k), 16'(k), 8'h33,
               (k % 2) ? 8'h00 : 8'hFF, 1'b0);
    end
    // R2 overlapping forward copy replicates the first byte
    run_case(8'hB0, 16'h0200, 16'h0201, 16'd6, 8'h00, 8'hA5, 1'b0);
    // R2 pointer wrap through zero
    run_case(8'hB8, 16'h0001, 16'h0802, 16'd3, 8'h00, 8'h5A, 1'b0);

    // R3 R7 R8 scan: match position sweep, count 4
    for (int ai = 0; ai < 4; ai++) begin
      for (int p = 0; p <= 5; p++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [15:0] base;
          logic [7:0] v;
          base = 16'h0A00 + 16'(ai * 32);
          for (int j = -6; j <= 6; j++) begin
            v = 8'((j * 29 + ai * 7 + 3) & 255);
            if (v == avals[ai]) v = v ^ 8'h01;
            poke(base + 16'(j), v);
          end
          if (p < 4) poke(dir ? base - 16'(p) : base + 16'(p), avals[ai]);
          run_case(dir ? 8'hB9 : 8'hB1, base, 16'h0123, 16'd4, avals[ai],
                   (p % 2) ? 8'h29 : 8'hD6, 1'b0);
        end
      end
    end

    // R9 zero count treated as 65536, match on second byte
    poke(16'h0C00, 8'h11);
    poke(16'h0C01, 8'h77);
    run_case(8'hB1, 16'h0C00, 16'h0000, 16'h0000, 8'h77, 8'h00, 1'b0);
    chk(bc_out == 16'hFFFE, "R9 count wrapped", bc_out, 16'hFFFE);

    // R11 command offered mid-run is ignored
    run_case(8'hB0, 16'h0300, 16'h0500, 16'd5, 8'h00, 8'h00, 1'b1);

    // R1 illegal opcodes dropped
    hold_hl = hl_out;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      cmd_pfx = (t == 1) ? 8'hDD : 8'hED;
      cmd_op  = (t == 0) ? 8'hB2 : (t == 1) ? 8'hB0 : 8'hA0;
      hl_in = 16'h0F0F; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      bad = 0;
      for (int c = 0; c < 30; c++) begin
        if (busy || mem_rd || mem_wr || done) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R1 illegal opcode no activity", bad, 0);
      chk(hl_out == hold_hl, "R1 illegal opcode outputs kept", hl_out, hold_hl);
    end

    // R12 reset mid-run
    @(negedge clk);
    cmd_pfx = 8'hED; cmd_op = 8'hB0; hl_in = 16'h0100; de_in = 16'h0600;
    bc_in = 16'd50; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy == 1'b1, "R12 run active before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && cmd_ready == 1 && done == 0, "R12 idle after reset", busy, 0);
    chk(mem_rd == 0 && mem_wr == 0, "R12 strobes low after reset", mem_wr, 0);
    for (int i = 0; i < 4096; i++) rm[i] = mem[i];
    run_case(8'hB9, 16'h0500, 16'h0000, 16'd3, 8'hEE, 8'h01, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule